// File: doc/BRIEF.md
# Multichannel Polyphase Bit-Serial Decimator

This block is one decimate-by-20 FIR stage for eight time-interleaved, independent channels. Samples arrive one at a time on a valid/ready input together with a channel index. Each channel keeps its own sample counter, and every accepted sample is routed to one of twenty polyphase arms according to that counter. Each arm keeps a short per-channel tap line of four words. It evaluates its partial dot product without multipliers: it walks the bits of its four taps from LSB to MSB, uses the four bits of each step to address a 16-entry table of precomputed coefficient sums, and shift-adds the result into an accumulator. On the sign-bit step it subtracts instead of adding.

The twenty arms are shared by all channels. Each arm has one serial engine that handles one channel word at a time over DW cycles, so the arm's tap lines act as a staging buffer that holds a word for every channel at once. When the last arm finishes a channel's word for the current decimation period, the block adds the twenty partials at full precision. It rounds the sum half-up to the output width and emits it with the channel index as a one-cycle pulse. The data width is a parameter. 16 bits is the default, and 24 or 32 bits are supported.

Top module: `poly_da_decim`

## Requirements
- R1: While rst_ni is low and in the cycle after it rises, out_valid_o is 0 and in_ready_o is 1. Reset clears all tap lines, phase counters, partials and engines, so the outputs after reset are computed from a zero history.
- R2: Channel c's n-th accepted sample after reset, counting from 0, enters arm n mod 20 of channel c and becomes tap 0 of that arm's line, with older taps shifting up by one. Channels never share tap lines or counters.
- R3: An output for channel c equals floor((S + 2^(RND_SH-1)) / 2^RND_SH). S is the sum over arms a and taps t of COEF[a*TAPS+t] times x(a,t,c), where x(a,t,c) is the t-th most recent sample held by arm a for channel c. Coefficient k is the signed field COEFS[k*CW +: CW].
- R4: Each group of 20 accepted samples of a channel produces exactly one output for that channel. The output is a single-cycle out_valid_o pulse carrying that channel on out_ch_o.
- R5: Each arm runs one word at a time. The engine starts on the clock edge after it sees a waiting word, takes DW further edges, and out_valid_o rises on the edge that completes the last bit of the last arm. Among waiting channels, an arm serves the lowest channel index first. Arms 0..18 do not start a channel's next-period word until that channel's output has been emitted, and arm 19 starts a channel only when arms 0..18 have finished that channel's current period.
- R6: in_ready_o is 0 exactly while the target arm (given by in_ch_i's phase) still holds an unfinished word for in_ch_i. A sample offered while in_ready_o is 0 is not taken and changes nothing.
- R7: Two's-complement inputs are exact at the extremes, including repeated -2^(DW-1) and 2^(DW-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample offered |
| in_ch_i | input | $clog2(N_CH) | Channel of the offered sample |
| in_data_i | input | DW | Signed sample |
| in_ready_o | output | 1 | Sample is taken when valid and ready are both high |
| out_valid_o | output | 1 | One-cycle output pulse |
| out_ch_o | output | $clog2(N_CH) | Channel of the output |
| out_data_o | output | OW | Signed rounded output, OW = DW+CW+$clog2(TAPS)+$clog2(DEC)+1-RND_SH |

## Verification
A misrouted sample or a corrupted tap line shows up as a wrong out_data_o on that channel at the end of the same decimation period, and it stays wrong for up to four periods while the bad word remains in a tap. A scheduling fault, such as a wrong start order, a missing wait on the other arms or a stuck pending flag, shifts the out_valid_o pulse or the in_ready_o level by at least one cycle. It is caught in the first affected cycle by the per-cycle comparison against a behavioural model. A sign-step error appears only on negative inputs, so the extreme-value runs expose it at the next output of that channel.

// File: rtl/poly_da_pkg.sv
package poly_da_pkg;
  localparam int DEF_DEC  = 20;
  localparam int DEF_TAPS = 4;
  localparam int DEF_CW   = 12;

  // default coefficient set, signed CW-bit fields
  function automatic logic [DEF_DEC*DEF_TAPS*DEF_CW-1:0] default_coefs();
    logic [DEF_DEC*DEF_TAPS*DEF_CW-1:0] v;
    int c;
    v = '0;
    for (int k = 0; k < DEF_DEC*DEF_TAPS; k++) begin
      c = ((k*149 + 23) % 2001) - 1000;
      v[k*DEF_CW +: DEF_CW] = DEF_CW'(c);
    end
    return v;
  endfunction
endpackage

// File: rtl/poly_da_arm.sv
module poly_da_arm #(
  parameter int DW = 16,
  parameter int CW = 12,
  parameter int TAPS = 4,
  parameter int N_CH = 8,
  parameter bit IS_LAST = 1'b0,
  parameter logic [TAPS*CW-1:0] ARM_COEF = '0,
  localparam int LW = CW + $clog2(TAPS),
  localparam int PW = LW + DW,
  localparam int CHW = $clog2(N_CH),
  localparam int BW = $clog2(DW)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [CHW-1:0]                wr_ch_i,
  input  logic [DW-1:0]                 wr_data_i,
  input  logic [N_CH-1:0]               allow_i,
  input  logic                          clr_i,
  input  logic [CHW-1:0]                clr_ch_i,
  output logic [N_CH-1:0]               pend_o,
  output logic [N_CH-1:0]               done_o,
  output logic                          busy_o,
  output logic [CHW-1:0]                cur_ch_o,
  output logic                          fin_o,
  output logic [PW-1:0]                 fin_val_o,
  output logic [N_CH-1:0][PW-1:0]       part_o
);
  localparam int LUT_N = 2**TAPS;

  function automatic logic [LUT_N*LW-1:0] build_lut();
    logic [LUT_N*LW-1:0] v;
    int s;
    v = '0;
    for (int e = 0; e < LUT_N; e++) begin
      s = 0;
      for (int t = 0; t < TAPS; t++)
        if (((e >> t) & 1) == 1) s += int'($signed(ARM_COEF[t*CW +: CW]));
      v[e*LW +: LW] = LW'(s);
    end
    return v;
  endfunction

  localparam logic [LUT_N*LW-1:0] LUT_P = build_lut();

  logic [DW-1:0]           dl_q [N_CH][TAPS];
  logic [N_CH-1:0]         pend_q, done_q;
  logic                    busy_q;
  logic [CHW-1:0]          ch_q;
  logic [BW-1:0]           bit_q;
  logic signed [PW-1:0]    acc_q;
  logic [N_CH-1:0][PW-1:0] part_q;

  logic [TAPS-1:0]      addr;
  logic [LW-1:0]        lut_v;
  logic signed [PW-1:0] term, acc_nxt;
  logic                 last_bit;
  logic [N_CH-1:0]      cand;
  logic [CHW-1:0]       pick;

  always_comb begin
    for (int t = 0; t < TAPS; t++) addr[t] = dl_q[ch_q][t][bit_q];
    lut_v    = LUT_P[int'(addr)*LW +: LW];
    term     = $signed({{(PW-LW){lut_v[LW-1]}}, lut_v}) <<< bit_q;
    last_bit = (bit_q == BW'(DW-1));
    // sign-bit step carries negative weight
    acc_nxt  = last_bit ? acc_q - term : acc_q + term;
  end

  always_comb begin
    cand = pend_q & ~done_q & allow_i;
    pick = '0;
    for (int c = N_CH-1; c >= 0; c--) if (cand[c]) pick = CHW'(c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CH; c++)
        for (int t = 0; t < TAPS; t++) dl_q[c][t] <= '0;
      pend_q <= '0;
      done_q <= '0;
      busy_q <= 1'b0;
      ch_q   <= '0;
      bit_q  <= '0;
      acc_q  <= '0;
      part_q <= '0;
    end else begin
      if (wr_i) begin
        pend_q[wr_ch_i]     <= 1'b1;
        dl_q[wr_ch_i][0]    <= wr_data_i;
        for (int t = 1; t < TAPS; t++) dl_q[wr_ch_i][t] <= dl_q[wr_ch_i][t-1];
      end
      if (busy_q) begin
        if (last_bit) begin
          busy_q         <= 1'b0;
          pend_q[ch_q]   <= 1'b0;
          part_q[ch_q]   <= acc_nxt;
          if (!IS_LAST) done_q[ch_q] <= 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
          acc_q <= acc_nxt;
        end
      end else if (|cand) begin
        busy_q <= 1'b1;
        ch_q   <= pick;
        bit_q  <= '0;
        acc_q  <= '0;
      end
      if (clr_i) done_q[clr_ch_i] <= 1'b0;
    end
  end

  assign pend_o    = pend_q;
  assign done_o    = done_q;
  assign busy_o    = busy_q;
  assign cur_ch_o  = ch_q;
  assign fin_o     = busy_q & last_bit;
  assign fin_val_o = acc_nxt;
  assign part_o    = part_q;
endmodule

// File: rtl/poly_da_sum.sv
module poly_da_sum #(
  parameter int DEC = 20,
  parameter int PW = 30,
  parameter int RND_SH = 12,
  localparam int SUM_W = PW + $clog2(DEC),
  localparam int RW = SUM_W + 1,
  localparam int OW = RW - RND_SH
) (
  input  logic [DEC-1:0][PW-1:0] term_i,
  output logic [OW-1:0]          rnd_o
);
  logic signed [RW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int a = 0; a < DEC; a++)
      acc += $signed({{(RW-PW){term_i[a][PW-1]}}, term_i[a]});
    acc += RW'(1) <<< (RND_SH-1);
    rnd_o = acc[RW-1:RND_SH];
  end
endmodule

// File: rtl/poly_da_decim.sv
module poly_da_decim #(
  parameter int N_CH = 8,
  parameter int DEC = poly_da_pkg::DEF_DEC,
  parameter int TAPS = poly_da_pkg::DEF_TAPS,
  parameter int DW = 16,
  parameter int CW = poly_da_pkg::DEF_CW,
  parameter int RND_SH = 12,
  parameter logic [DEC*TAPS*CW-1:0] COEFS = poly_da_pkg::default_coefs(),
  localparam int CHW = $clog2(N_CH),
  localparam int PHW = $clog2(DEC),
  localparam int LW = CW + $clog2(TAPS),
  localparam int PW = LW + DW,
  localparam int OW = PW + $clog2(DEC) + 1 - RND_SH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [CHW-1:0]  in_ch_i,
  input  logic [DW-1:0]   in_data_i,
  output logic            in_ready_o,
  output logic            out_valid_o,
  output logic [CHW-1:0]  out_ch_o,
  output logic [OW-1:0]   out_data_o
);
  logic [N_CH-1:0][PHW-1:0]          phase_q;
  logic [DEC-1:0][N_CH-1:0]          pend_a, done_a;
  logic [DEC-1:0][N_CH-1:0][PW-1:0]  part_a;
  logic [DEC-1:0]                    arm_fin, arm_busy;
  logic [DEC-1:0][CHW-1:0]           arm_ch;
  logic [DEC-1:0][PW-1:0]            arm_val;
  logic [DEC-1:0][PW-1:0]            sum_in;
  logic [N_CH-1:0]                   allow_lst;
  logic [PHW-1:0]                    ph_in;
  logic                              take;
  logic [OW-1:0]                     rnd;

  assign ph_in      = phase_q[in_ch_i];
  assign in_ready_o = ~pend_a[ph_in][in_ch_i];
  assign take       = in_valid_i & in_ready_o;

  // last arm waits until every other arm closed the period
  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      allow_lst[c] = 1'b1;
      for (int a = 0; a < DEC-1; a++) allow_lst[c] &= done_a[a][c];
    end
  end

  for (genvar a = 0; a < DEC; a++) begin : g_arm
    logic [N_CH-1:0] allow;
    if (a == DEC-1) begin : g_lst
      assign allow     = allow_lst;
      assign sum_in[a] = arm_val[a];
    end else begin : g_mid
      assign allow     = '1;
      assign sum_in[a] = part_a[a][arm_ch[DEC-1]];
    end
    poly_da_arm #(
      .DW(DW), .CW(CW), .TAPS(TAPS), .N_CH(N_CH),
      .IS_LAST(a == DEC-1),
      .ARM_COEF(COEFS[a*TAPS*CW +: TAPS*CW])
    ) i_arm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (take && (ph_in == PHW'(a))),
      .wr_ch_i  (in_ch_i),
      .wr_data_i(in_data_i),
      .allow_i  (allow),
      .clr_i    (arm_fin[DEC-1]),
      .clr_ch_i (arm_ch[DEC-1]),
      .pend_o   (pend_a[a]),
      .done_o   (done_a[a]),
      .busy_o   (arm_busy[a]),
      .cur_ch_o (arm_ch[a]),
      .fin_o    (arm_fin[a]),
      .fin_val_o(arm_val[a]),
      .part_o   (part_a[a])
    );
  end

  poly_da_sum #(.DEC(DEC), .PW(PW), .RND_SH(RND_SH)) i_sum (
    .term_i(sum_in),
    .rnd_o (rnd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= '0;
      out_valid_o <= 1'b0;
      out_ch_o    <= '0;
      out_data_o  <= '0;
    end else begin
      if (take) phase_q[in_ch_i] <= (ph_in == PHW'(DEC-1)) ? '0 : ph_in + 1'b1;
      out_valid_o <= arm_fin[DEC-1];
      if (arm_fin[DEC-1]) begin
        out_ch_o   <= arm_ch[DEC-1];
        out_data_o <= rnd;
      end
    end
  end
endmodule

// File: rtl/poly_da_chk.sv
module poly_da_chk #(
  parameter int N_CH = 8,
  parameter int DEC = 20,
  localparam int CHW = $clog2(N_CH),
  localparam int PHW = $clog2(DEC)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic [CHW-1:0]           in_ch_i,
  input logic                     in_ready_o,
  input logic                     out_valid_o,
  input logic [CHW-1:0]           out_ch_o,
  input logic [N_CH-1:0][PHW-1:0] phase_q,
  input logic [DEC-1:0][N_CH-1:0] pend_a,
  input logic [DEC-1:0][N_CH-1:0] done_a,
  input logic [DEC-1:0]           arm_fin,
  input logic [DEC-1:0]           arm_busy,
  input logic [DEC-1:0][CHW-1:0]  arm_ch
);
  logic [DEC-1:0] col_out, col_lst;
  always_comb begin
    for (int a = 0; a < DEC; a++) begin
      col_out[a] = done_a[a][out_ch_o];
      col_lst[a] = done_a[a][arm_ch[DEC-1]];
    end
  end

  a_r2_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase_q[in_ch_i]) < DEC);

  a_r6_stall_keeps_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> (phase_q[$past(in_ch_i)] == $past(phase_q[in_ch_i])));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  a_r4_done_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (col_out == '0));

  a_r5_last_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_busy[DEC-1]) |-> (&col_lst[DEC-2:0]));

  for (genvar a = 0; a < DEC; a++) begin : g_fin
    a_r6_fin_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_fin[a] |-> pend_a[a][arm_ch[a]]);
  end
endmodule

bind poly_da_decim poly_da_chk #(.N_CH(N_CH), .DEC(DEC)) i_chk (.*);

// File: tb/test_poly_da_decim.sv
module test_poly_da_decim;
  localparam int N_CH = 8, DEC = 20, TAPS = 4, DW = 16, CW = 12, SH = 12;
  localparam int OW = CW + $clog2(TAPS) + DW + $clog2(DEC) + 1 - SH;
  localparam logic [DEC*TAPS*CW-1:0] CF = poly_da_pkg::default_coefs();
  localparam int WD = 150000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic [2:0] in_ch_i = '0;
  logic [DW-1:0] in_data_i = '0;
  logic in_ready_o, out_valid_o;
  logic [2:0] out_ch_o;
  logic [OW-1:0] out_data_o;

  poly_da_decim i_poly_da_decim (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  string dtag = "R3";

  // behavioural model state
  longint dl [DEC][N_CH][TAPS];
  longint part [DEC][N_CH];
  bit pend [DEC][N_CH], done [DEC][N_CH];
  bit busy [DEC];
  int ach [DEC], abit [DEC], phs [N_CH];
  bit m_ov; int m_och; longint m_od;
  int seed = 32'h1234_5677;

  function automatic longint coef(int k);
    return longint'($signed(CF[k*CW +: CW]));
  endfunction

  function automatic int rnd_next();
    seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < DEC; a++) begin
      busy[a] = 0; ach[a] = 0; abit[a] = 0;
      for (int c = 0; c < N_CH; c++) begin
        pend[a][c] = 0; done[a][c] = 0; part[a][c] = 0;
        for (int t = 0; t < TAPS; t++) dl[a][c][t] = 0;
      end
    end
    for (int c = 0; c < N_CH; c++) phs[c] = 0;
    m_ov = 0; m_och = 0; m_od = 0;
  endtask

  task automatic model_advance(bit took, int ch, longint d);
    bit po [DEC][N_CH];
    bit dn [DEC][N_CH];
    bit nov, clr, ok;
    int clr_ch;
    longint s, v;
    po = pend; dn = done; nov = 0; clr = 0; clr_ch = 0;
    for (int a = 0; a < DEC; a++) begin
      if (busy[a]) begin
        if (abit[a] == DW-1) begin
          v = 0;
          for (int t = 0; t < TAPS; t++) v += coef(a*TAPS+t) * dl[a][ach[a]][t];
          busy[a] = 0; pend[a][ach[a]] = 0; part[a][ach[a]] = v;
          if (a < DEC-1) done[a][ach[a]] = 1;
          else begin
            s = v;
            for (int b = 0; b < DEC-1; b++) s += part[b][ach[a]];
            nov = 1; m_och = ach[a]; m_od = (s + (longint'(1) <<< (SH-1))) >>> SH;
            clr = 1; clr_ch = ach[a];
          end
        end else abit[a]++;
      end else begin
        for (int c = 0; c < N_CH; c++) begin
          ok = po[a][c] && !dn[a][c];
          if (a == DEC-1) for (int b = 0; b < DEC-1; b++) ok = ok && dn[b][c];
          if (ok && !busy[a]) begin busy[a] = 1; ach[a] = c; abit[a] = 0; end
        end
      end
    end
    if (took) begin
      pend[phs[ch]][ch] = 1;
      for (int t = TAPS-1; t > 0; t--) dl[phs[ch]][ch][t] = dl[phs[ch]][ch][t-1];
      dl[phs[ch]][ch][0] = d;
      phs[ch] = (phs[ch] == DEC-1) ? 0 : phs[ch] + 1;
    end
    if (clr) for (int b = 0; b < DEC; b++) done[b][clr_ch] = 0;
    m_ov = nov;
  endtask

  // one clock: compare at negedge, drive, predict the next edge
  task automatic step(bit v, int ch, longint d, output bit took);
    bit rdy;
    @(negedge clk_i);
    check(out_valid_o == m_ov, "R4,R5 out_valid", out_valid_o, m_ov);
    if (m_ov) begin
      check(out_ch_o == 3'(m_och), "R4 out_ch", out_ch_o, m_och);
      check(longint'($signed(out_data_o)) == m_od, dtag, $signed(out_data_o), m_od);
    end
    in_valid_i = v; in_ch_i = 3'(ch); in_data_i = DW'(d);
    #1;
    rdy = !pend[phs[ch]][ch];
    check(in_ready_o == rdy, "R6 in_ready", in_ready_o, rdy);
    took = v && rdy;
    model_advance(took, ch, d);
  endtask

  task automatic send(int ch, longint d);
    bit took;
    do step(1'b1, ch, d, took); while (!took);
  endtask

  task automatic idle(int n);
    bit took;
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, took);
  endtask

  task automatic reset_phase();
    @(negedge clk_i);
    in_valid_i = 1'b0; rst_ni = 1'b0; model_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check(out_valid_o == 1'b0, "R1 out_valid in reset", out_valid_o, 0);
      check(in_ready_o == 1'b1, "R1 ready in reset", in_ready_o, 1);
    end
    rst_ni = 1'b1;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc >= WD) begin
      checks++; errors++;
      $display("FAIL R5 watchdog: cycles=%0d expected below %0d", cyc, WD);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    reset_phase();
    // R1: quiet after reset
    idle(4);
    // R2/R3: interleaved channels at full rate
    for (int r = 0; r < 120; r++)
      for (int c = 0; c < N_CH; c++) send(c, longint'($signed(16'(rnd_next()))));
    idle(200);
    // R2/R6: one channel back to back, arms stall
    dtag = "R2 single-channel data";
    for (int i = 0; i < 100; i++) send(5, longint'($signed(16'(rnd_next()))));
    idle(200);
    // R7: extremes
    dtag = "R7 extreme data";
    for (int i = 0; i < 80; i++) send(2, -32768);
    for (int i = 0; i < 80; i++) send(2, (i % 2 == 0) ? -32768 : 32767);
    for (int i = 0; i < 80; i++) send(6, 32767);
    idle(200);
    // R1: reset mid-run, then history must be zero
    for (int i = 0; i < 13; i++) send(1, 700);
    reset_phase();
    dtag = "R1 post-reset data";
    for (int i = 0; i < 40; i++) send(1, 1000);
    idle(200);
    // R3: random channel order
    dtag = "R3 random-order data";
    for (int i = 0; i < 800; i++) send(rnd_next() & 7, longint'($signed(16'(rnd_next()))));
    idle(300);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule